// File: doc/BRIEF.md
# Paged Program Sequencer

This block produces the instruction address for a program store of 1024 words. The store is split into 16 pages of 64 words. The address is the concatenation of a 4-bit page register, in the upper bits, and a 6-bit in-page counter, in the lower bits. The in-page counter does not count in binary. It steps through a shift-register sequence that covers all 64 in-page values, so straight-line code never leaves its page. A separate 4-bit page buffer stages a page change. A load-page command writes a constant into the buffer, and the buffer reaches the page register only when a branch or call is taken.

Branches and calls are conditional on the status bit and are taken only when it is 1. A call saves the sequential successor of the current counter value in a single return register. At the same moment it swaps the page register and the page buffer, so the buffer then holds the return page. A return brings both back. There is one return level only: a second call made before a return replaces the saved counter value.

All state changes happen on clock edges where the instruction-cycle strobe is high. The surrounding machine raises that strobe once per instruction, which lasts six clocks. Instruction decoding and the program store itself sit outside this block.

Top module: `paged_seq`

## Requirements
- R1: While reset is active and after it is released, the address reads 10'h3C0 (page 15, in-page value 0). The page buffer also holds 15, so a branch taken before any load-page stays on page 15.
- R2: On clock edges where `cycleStb` is low, the address does not change, whatever the command and status inputs are.
- R3: A strobed instruction that is not a taken jump and not a return keeps the page. It moves the in-page value `s` to `{s[4:0], f}`, where `f = ~(s[5]^s[4]) ^ (s[4:0]==5'b11111)`. Starting from 0, this visits all 64 values and returns to 0 after 64 steps.
- R4: Load-page writes `constIn` into the page buffer. The page register is left unchanged, and the in-page value advances as in R3.
- R5: A branch with status 1 loads `target` into the in-page counter and copies the page buffer into the page register.
- R6: A branch or call with status 0 advances as in R3. It changes neither the page register nor the return register.
- R7: A call with status 1 loads `target` and the buffered page, as a branch does. It also saves the R3 successor of the current in-page value in the return register, and puts the old page into the page buffer.
- R8: A return, which needs no status, restores the in-page value from the return register and the page from the page buffer.
- R9: A second taken call before a return overwrites the saved in-page value. The following return goes to the successor of the second call.
- R10: When commands coincide, return takes precedence over a call, and a call over a branch. A load-page that arrives with a taken branch or a return is dropped. A load-page that arrives with an untaken branch still writes the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleStb | input | 1 | One-clock strobe marking the end of an instruction cycle |
| cmdLoadPage | input | 1 | Write `constIn` into the page buffer |
| cmdBranch | input | 1 | Conditional branch |
| cmdCall | input | 1 | Conditional subroutine call |
| cmdReturn | input | 1 | Return from subroutine |
| status | input | 1 | Condition bit; 1 allows a branch or call |
| target | input | 6 | In-page jump target |
| constIn | input | 4 | Page constant for load-page |
| progAddr | output | 10 | Program address, {page, in-page value} |

## Verification
The bench builds the block with its default widths: a 4-bit page and a 6-bit in-page counter. At that size the whole state space is small enough to cover completely. One run walks the full 64-state in-page cycle. It also branches to every in-page target on every one of the 16 pages, so each of the 1024 addresses is reached through the buffer path. Call, return, untaken and overlapping-command cases are checked against an arithmetic model of the page, buffer, counter and return registers.

// File: rtl/paged_seq_pkg.sv
package paged_seq_pkg;

  // Per-cycle strobes from the control module to the datapath.
  typedef struct packed {
    logic advance;  // take the sequential successor
    logic jump;     // load target and the buffered page
    logic saveRet;  // jump is a call: save return, swap pages
    logic restore;  // return from subroutine
    logic loadBuf;  // write constant into page buffer
  } seqStrobes_t;

endpackage

// File: rtl/seq_lfsr_step.sv
// Successor function of the in-page counter. The XNOR shift register
// has an extra term that splices the all-ones state into the cycle, so
// every value of the counter is visited.
module seq_lfsr_step #(
  parameter int          PC_W     = 6,
  parameter logic [PC_W-1:0] TAP_MASK = 6'b110000
) (
  input  logic [PC_W-1:0] cur,
  output logic [PC_W-1:0] nxt
);
  localparam int LOW_W = PC_W - 1;

  logic tapXnor;
  logic lowAllOnes;
  logic feedBit;

  always_comb begin
    tapXnor    = ~(^(cur & TAP_MASK));
    lowAllOnes = &cur[LOW_W-1:0];
    feedBit    = tapXnor ^ lowAllOnes;
    nxt        = {cur[LOW_W-1:0], feedBit};
  end
endmodule

// File: rtl/seq_ctrl.sv
// Turns the decoded commands and status into one set of strobes for a cycle.
module seq_ctrl
  import paged_seq_pkg::*;
(
  input  logic        cycleStb,
  input  logic        cmdLoadPage,
  input  logic        cmdBranch,
  input  logic        cmdCall,
  input  logic        cmdReturn,
  input  logic        status,
  output seqStrobes_t stb
);
  logic isReturn;
  logic isTaken;

  always_comb begin
    isReturn    = cycleStb & cmdReturn;
    isTaken     = cycleStb & ~cmdReturn & (cmdBranch | cmdCall) & status;
    stb.restore = isReturn;
    stb.jump    = isTaken;
    stb.saveRet = isTaken & cmdCall;
    stb.advance = cycleStb & ~isReturn & ~isTaken;
    stb.loadBuf = cycleStb & ~isReturn & ~isTaken & cmdLoadPage;
  end
endmodule

// File: rtl/seq_datapath.sv
// Holds the page register, page buffer, in-page counter and return register.
module seq_datapath
  import paged_seq_pkg::*;
#(
  parameter int              PAGE_W     = 4,
  parameter int              PC_W       = 6,
  parameter logic [PC_W-1:0] TAP_MASK   = 6'b110000,
  parameter logic [PAGE_W-1:0] RESET_PAGE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       stb,
  input  logic [PC_W-1:0]   target,
  input  logic [PAGE_W-1:0] constIn,
  output logic [PAGE_W-1:0] pageQ,
  output logic [PC_W-1:0]   pcQ
);
  logic [PAGE_W-1:0] pageReg;
  logic [PAGE_W-1:0] pageBuf;
  logic [PC_W-1:0]   pcReg;
  logic [PC_W-1:0]   retReg;
  logic [PC_W-1:0]   pcSucc;

  seq_lfsr_step #(.PC_W(PC_W), .TAP_MASK(TAP_MASK)) u_step (
    .cur(pcReg),
    .nxt(pcSucc)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= RESET_PAGE;
      pageBuf <= RESET_PAGE;
      pcReg   <= '0;
      retReg  <= '0;
    end else if (stb.restore) begin
      pcReg   <= retReg;
      pageReg <= pageBuf;
    end else if (stb.jump) begin
      pcReg   <= target;
      pageReg <= pageBuf;
      if (stb.saveRet) begin
        retReg  <= pcSucc;
        pageBuf <= pageReg;
      end
    end else if (stb.advance) begin
      pcReg <= pcSucc;
      if (stb.loadBuf) pageBuf <= constIn;
    end
  end

  assign pageQ = pageReg;
  assign pcQ   = pcReg;
endmodule

// File: rtl/paged_seq.sv
module paged_seq
  import paged_seq_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int PC_W   = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cycleStb,
  input  logic                   cmdLoadPage,
  input  logic                   cmdBranch,
  input  logic                   cmdCall,
  input  logic                   cmdReturn,
  input  logic                   status,
  input  logic [PC_W-1:0]        target,
  input  logic [PAGE_W-1:0]      constIn,
  output logic [PAGE_W+PC_W-1:0] progAddr
);
  localparam logic [PC_W-1:0]   TAP_MASK   = PC_W'(2'b11) << (PC_W - 2);
  localparam logic [PAGE_W-1:0] RESET_PAGE = '1;

  seqStrobes_t       stb;
  logic [PAGE_W-1:0] pageQ;
  logic [PC_W-1:0]   pcQ;

  seq_ctrl u_ctrl (
    .cycleStb   (cycleStb),
    .cmdLoadPage(cmdLoadPage),
    .cmdBranch  (cmdBranch),
    .cmdCall    (cmdCall),
    .cmdReturn  (cmdReturn),
    .status     (status),
    .stb        (stb)
  );

  seq_datapath #(
    .PAGE_W    (PAGE_W),
    .PC_W      (PC_W),
    .TAP_MASK  (TAP_MASK),
    .RESET_PAGE(RESET_PAGE)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .target (target),
    .constIn(constIn),
    .pageQ  (pageQ),
    .pcQ    (pcQ)
  );

  assign progAddr = {pageQ, pcQ};
endmodule

// File: rtl/paged_seq_chk.sv
module paged_seq_chk #(
  parameter int PAGE_W = 4,
  parameter int PC_W   = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cycleStb,
  input logic                   cmdBranch,
  input logic                   cmdCall,
  input logic                   cmdReturn,
  input logic                   status,
  input logic [PC_W-1:0]        target,
  input logic [PAGE_W+PC_W-1:0] progAddr
);
  localparam int ADDR_W = PAGE_W + PC_W;

  logic [PAGE_W-1:0] pageObs;
  logic [PC_W-1:0]   pcObs;
  logic              plainStep;

  assign pageObs   = progAddr[ADDR_W-1:PC_W];
  assign pcObs     = progAddr[PC_W-1:0];
  assign plainStep = cycleStb & ~cmdReturn & ~cmdBranch & ~cmdCall;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStb |=> $stable(progAddr));

  p_page_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    plainStep |=> $stable(pageObs));

  p_counter_moves_r3: assert property (@(posedge clk) disable iff (!rstN)
    plainStep |=> pcObs != $past(pcObs));

  p_branch_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStb && cmdBranch && !cmdCall && !cmdReturn && status)
      |=> pcObs == $past(target));

  p_untaken_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStb && !cmdReturn && (cmdBranch || cmdCall) && !status)
      |=> $stable(pageObs));

  p_call_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStb && cmdCall && !cmdReturn && status)
      |=> pcObs == $past(target));
endmodule

bind paged_seq paged_seq_chk #(.PAGE_W(PAGE_W), .PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cycleStb (cycleStb),
  .cmdBranch(cmdBranch),
  .cmdCall  (cmdCall),
  .cmdReturn(cmdReturn),
  .status   (status),
  .target   (target),
  .progAddr (progAddr)
);

// File: tb/test_paged_seq.sv
`timescale 1ns/1ps
module test_paged_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleStb = 1'b0;
  logic       cmdLoadPage = 1'b0;
  logic       cmdBranch = 1'b0;
  logic       cmdCall = 1'b0;
  logic       cmdReturn = 1'b0;
  logic       status = 1'b0;
  logic [5:0] target = '0;
  logic [3:0] constIn = '0;
  logic [9:0] progAddr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Independent model of the architectural state.
  int expPage, expBuf, expPc, expRet;

  always #10 clk = ~clk;

  paged_seq i_paged_seq (
    .clk(clk), .rstN(rstN), .cycleStb(cycleStb),
    .cmdLoadPage(cmdLoadPage), .cmdBranch(cmdBranch), .cmdCall(cmdCall),
    .cmdReturn(cmdReturn), .status(status), .target(target),
    .constIn(constIn), .progAddr(progAddr)
  );

  function automatic int refNext(int s);
    int b5, b4, fb;
    b5 = (s / 32) % 2;
    b4 = (s / 16) % 2;
    fb = (b5 == b4) ? 1 : 0;
    if ((s % 32) == 31) fb = 1 - fb;
    return ((s * 2) % 64) + fb;
  endfunction

  task automatic chk(input string tag);
    int expAddr;
    expAddr = expPage * 64 + expPc;
    vectors++;
    if (progAddr !== 10'(expAddr)) begin
      miscompares++;
      $display("FAIL %s: progAddr=%h expected=%h", tag, progAddr, 10'(expAddr));
    end
  endtask

  task automatic step(input bit lp, input bit br, input bit ca, input bit rt,
                      input bit st, input int tgt, input int k, input string tag);
    int tmp;
    @(negedge clk);
    cmdLoadPage = lp; cmdBranch = br; cmdCall = ca; cmdReturn = rt;
    status = st; target = 6'(tgt); constIn = 4'(k); cycleStb = 1'b1;
    @(negedge clk);
    cycleStb = 1'b0; cmdLoadPage = 0; cmdBranch = 0; cmdCall = 0;
    cmdReturn = 0; status = 0;
    if (rt) begin
      expPc = expRet; expPage = expBuf;
    end else if ((br || ca) && st) begin
      if (ca) begin
        expRet = refNext(expPc);
        tmp = expBuf; expBuf = expPage; expPage = tmp;
      end else begin
        expPage = expBuf;
      end
      expPc = tgt;
    end else begin
      expPc = refNext(expPc);
      if (lp) expBuf = k;
    end
    chk(tag);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit seen[64];
    int start;
    expPage = 15; expBuf = 15; expPc = 0; expRet = 0;
    repeat (3) @(negedge clk);
    chk("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release");

    // R2: commands toggle but no strobe.
    @(negedge clk);
    cmdBranch = 1; status = 1; target = 6'd33; cmdLoadPage = 1; constIn = 4'd2;
    repeat (6) @(negedge clk);
    cmdBranch = 0; status = 0; cmdLoadPage = 0;
    chk("R2 no strobe");

    // R1: reset buffer is page 15.
    step(0, 1, 0, 0, 1, 7, 0, "R1 buffer reset page");

    // R3: full in-page cycle.
    start = expPc;
    for (int i = 0; i < 64; i++) begin
      step(0, 0, 0, 0, 0, 0, 0, "R3 sequence");
      seen[expPc] = 1'b1;
    end
    begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < 64; i++) if (seen[i]) cnt++;
      vectors++;
      if (cnt != 64 || expPc != start) begin
        miscompares++;
        $display("FAIL R3 coverage: distinct=%0d end=%0d expected 64 and %0d",
                 cnt, expPc, start);
      end
    end

    // R4 and R5: every page, every target.
    for (int p = 0; p < 16; p++)
      for (int t = 0; t < 64; t++) begin
        step(1, 0, 0, 0, 0, 0, p, "R4 load page");
        step(0, 1, 0, 0, 1, t, 0, "R5 taken branch");
      end

    // R7 and R8: call then return.
    step(1, 0, 0, 0, 0, 0, 9, "R4 load page");
    step(0, 0, 0, 0, 0, 0, 0, "R3 sequence");
    step(0, 0, 1, 0, 1, 20, 0, "R7 taken call");
    step(0, 0, 0, 0, 0, 0, 0, "R3 in subroutine");
    step(0, 0, 0, 1, 0, 0, 0, "R8 return");

    // R6: untaken branch and call keep page and saved return.
    step(1, 0, 0, 0, 0, 0, 4, "R4 load page");
    step(0, 0, 1, 0, 1, 40, 0, "R7 taken call");
    step(0, 1, 0, 0, 0, 11, 0, "R6 untaken branch");
    step(0, 0, 1, 0, 0, 12, 0, "R6 untaken call");
    step(0, 0, 0, 1, 0, 0, 0, "R6 saved return intact");

    // R9: nested call overwrites.
    step(1, 0, 0, 0, 0, 0, 6, "R4 load page");
    step(0, 0, 1, 0, 1, 3, 0, "R9 first call");
    step(0, 0, 0, 0, 0, 0, 0, "R3 sequence");
    step(0, 0, 1, 0, 1, 50, 0, "R9 second call");
    step(0, 0, 0, 1, 0, 0, 0, "R9 return to second");

    // R10: overlapping commands.
    step(1, 0, 0, 0, 0, 0, 2, "R4 load page");
    step(0, 0, 1, 0, 1, 8, 0, "R7 taken call");
    step(0, 1, 1, 1, 1, 30, 0, "R10 return wins");
    step(1, 0, 0, 0, 0, 0, 5, "R4 load page");
    step(0, 1, 1, 0, 1, 17, 0, "R10 call beats branch");
    step(0, 0, 0, 1, 0, 0, 0, "R8 return");
    step(1, 0, 0, 0, 0, 0, 13, "R4 load page");
    step(1, 1, 0, 0, 1, 22, 3, "R10 load dropped on taken");
    step(0, 1, 0, 0, 1, 23, 0, "R10 buffer unchanged");
    step(1, 1, 0, 0, 0, 0, 8, "R10 load with untaken");
    step(0, 1, 0, 0, 1, 1, 0, "R10 load took effect");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule